// File: doc/BRIEF.md
# Inter-processor doorbell register

This block carries a one-deep message from a sender processor to a receiver processor. Each side reaches it through its own simple register port, with a write strobe, a read strobe, an address and 64-bit data. Three registers sit behind the ports.

The doorbell word holds a 30-bit message code that the block does not interpret, a busy flag and a done flag. The sender posts a code by writing the doorbell with busy set. While busy is high, the receiver sees a level request interrupt if it has enabled that interrupt. The receiver answers by writing busy back to 0, and it can set the done flag at the same time to raise its own, separately enabled, done interrupt.

A sender write that arrives while the channel is still busy is discarded. A sender write that loses a same-cycle race against a receiver doorbell write is also discarded. In both cases a sticky error bit records the loss, and the sender can read that bit, which clears it.

Top module: `ipc_doorbell`

## Requirements
- R1: After reset, the doorbell, interrupt-enable and error registers read as zero, and both interrupt outputs are low.
- R2: A sender write to the doorbell (offset 0x00) while busy is 0 stores write-data bit 63 as busy, bit 62 as done and bits 29:0 as the message code. The stored value reads back with those fields in the same positions.
- R3: Doorbell bits 61:30 always read as zero, whatever value was written to them.
- R4: `req_irq` equals busy AND request-enable (enable bit 1), registered. It changes on the clock edge after the one at which either input changes.
- R5: A receiver write to the doorbell updates only busy (bit 63) and done (bit 62). The stored message code is left unchanged.
- R6: `done_irq` equals done AND done-enable (enable bit 0), registered with the same one-cycle lag. Writing done back to 0 clears it.
- R7: The interrupt-enable register (offset 0x08) is written only by the receiver, and only bits 1:0 are stored. Bits 63:2 read as zero, and sender writes to this register have no effect.
- R8: A sender doorbell write while busy is 1 is discarded, and the doorbell contents stay unchanged.
- R9: When both ports write the doorbell in the same cycle, the receiver write is applied and the sender write is discarded.
- R10: The error flag (offset 0x10, bit 0) is set by every discarded sender doorbell write. A sender read of offset 0x10 clears it, and a set in the same cycle wins over the clear.
- R11: Both ports can read every register. Read data is registered and appears the cycle after the read strobe. Unmapped offsets read as zero, and a receiver read of the error register does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snd_wr | input | 1 | Sender write strobe |
| snd_rd | input | 1 | Sender read strobe |
| snd_addr | input | 5 | Sender byte offset |
| snd_wdata | input | 64 | Sender write data |
| snd_rdata | output | 64 | Sender read data, valid the cycle after the strobe |
| rcv_wr | input | 1 | Receiver write strobe |
| rcv_rd | input | 1 | Receiver read strobe |
| rcv_addr | input | 5 | Receiver byte offset |
| rcv_wdata | input | 64 | Receiver write data |
| rcv_rdata | output | 64 | Receiver read data, valid the cycle after the strobe |
| req_irq | output | 1 | Level request interrupt to the receiver |
| done_irq | output | 1 | Level done interrupt to the receiver |

## Verification
The bench posts a message whose reserved bits are set. A design that leaks those bits would return them on readback. It then posts again while busy, and a design that lets the write through would overwrite the message code and leave the error flag clear. It fires sender and receiver doorbell writes in the same cycle, which catches a priority inversion through the busy flag and the message code. It also toggles each interrupt enable with the flags held, and reads the error register from both sides, so that a missing one-cycle lag, a combinational shortcut or a clear from the wrong port shows up as an interrupt or error value in the wrong cycle.

// File: rtl/ipc_doorbell_pkg.sv
// Shared constants and the doorbell word layout.
// Assumes a 64-bit register word with busy and done in the top two bits.
package ipc_doorbell_pkg;
    localparam int DW          = 64;
    localparam int MSG_W       = 30;
    localparam int BUSY_BIT    = 63;
    localparam int DONE_BIT    = 62;
    localparam int EN_W        = 2;
    localparam int EN_REQ_BIT  = 1;
    localparam int EN_DONE_BIT = 0;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [MSG_W-1:0] msg;
    } dbell_t;

    // Place the doorbell fields into a full bus word with zeros elsewhere.
    function automatic logic [DW-1:0] pack_dbell(input dbell_t d);
        logic [DW-1:0] w;
        w = '0;
        w[BUSY_BIT]    = d.busy;
        w[DONE_BIT]    = d.done;
        w[MSG_W-1:0]   = d.msg;
        return w;
    endfunction
endpackage

// File: rtl/dbl_write_arb.sv
// Decodes both write ports and settles who may change the doorbell.
// Receiver writes win; a sender post goes through only if idle and uncontested.
module dbl_write_arb #(
    parameter int          ADDR_W = 5,
    parameter logic [4:0]  OFS_DB = 5'h00,
    parameter logic [4:0]  OFS_EN = 5'h08
) (
    input  logic              snd_wr,
    input  logic [ADDR_W-1:0] snd_addr,
    input  logic              rcv_wr,
    input  logic [ADDR_W-1:0] rcv_addr,
    input  logic              busy,
    output logic              snd_post,
    output logic              snd_drop,
    output logic              rcv_db_wr,
    output logic              rcv_en_wr
);
    logic snd_db_hit;

    // Address decode and fixed-priority resolution.
    always_comb begin
        snd_db_hit = snd_wr && (snd_addr == ADDR_W'(OFS_DB));
        rcv_db_wr  = rcv_wr && (rcv_addr == ADDR_W'(OFS_DB));
        rcv_en_wr  = rcv_wr && (rcv_addr == ADDR_W'(OFS_EN));
        snd_post   = snd_db_hit && !busy && !rcv_db_wr;
        snd_drop   = snd_db_hit && !snd_post;
    end
endmodule

// File: rtl/dbl_regs.sv
// Holds the doorbell word, the interrupt enables and the sticky error flag.
// Assumes the write decode has already applied priority.
module dbl_regs
    import ipc_doorbell_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            snd_post,
    input  logic            snd_drop,
    input  logic            rcv_db_wr,
    input  logic            rcv_en_wr,
    input  logic            err_clr,
    input  logic [DW-1:0]   snd_wdata,
    input  logic [DW-1:0]   rcv_wdata,
    output dbell_t          db_q,
    output logic [EN_W-1:0] en_q,
    output logic            err_q
);
    // Doorbell: receiver changes only the flags, the sender loads everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_q <= '0;
        end else if (rcv_db_wr) begin
            db_q.busy <= rcv_wdata[BUSY_BIT];
            db_q.done <= rcv_wdata[DONE_BIT];
        end else if (snd_post) begin
            db_q.busy <= snd_wdata[BUSY_BIT];
            db_q.done <= snd_wdata[DONE_BIT];
            db_q.msg  <= snd_wdata[MSG_W-1:0];
        end
    end

    // Interrupt enables, receiver-owned.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (rcv_en_wr) en_q <= rcv_wdata[EN_W-1:0];
    end

    // Sticky error: a new drop beats a same-cycle read clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_q <= 1'b0;
        else if (snd_drop) err_q <= 1'b1;
        else if (err_clr)  err_q <= 1'b0;
    end
endmodule

// File: rtl/dbl_irq.sv
// Registers the two level interrupts from flag and enable state.
// Assumes flags and enables are already registered, so the outputs lag one cycle.
module dbl_irq
    import ipc_doorbell_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic            done,
    input  logic [EN_W-1:0] en,
    output logic            req_irq,
    output logic            done_irq
);
    // Gate each flag with its own enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_irq  <= 1'b0;
            done_irq <= 1'b0;
        end else begin
            req_irq  <= busy & en[EN_REQ_BIT];
            done_irq <= done & en[EN_DONE_BIT];
        end
    end
endmodule

// File: rtl/dbl_rd_port.sv
// One registered read port over the three registers.
// Assumes unmapped offsets must read zero; data holds between reads.
module dbl_rd_port
    import ipc_doorbell_pkg::*;
#(
    parameter int         ADDR_W  = 5,
    parameter logic [4:0] OFS_DB  = 5'h00,
    parameter logic [4:0] OFS_EN  = 5'h08,
    parameter logic [4:0] OFS_ERR = 5'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     db_word,
    input  logic [EN_W-1:0]   en,
    input  logic              err,
    output logic [DW-1:0]     rdata
);
    logic [DW-1:0] sel;

    // Select the addressed register.
    always_comb begin
        sel = '0;
        if (addr == ADDR_W'(OFS_DB))       sel = db_word;
        else if (addr == ADDR_W'(OFS_EN))  sel[EN_W-1:0] = en;
        else if (addr == ADDR_W'(OFS_ERR)) sel[0] = err;
    end

    // Capture on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= sel;
    end
endmodule

// File: rtl/ipc_doorbell.sv
// Two-port inter-processor doorbell: sender posts, receiver acknowledges.
// Assumes both ports share one clock; receiver writes have priority.
module ipc_doorbell
    import ipc_doorbell_pkg::*;
#(
    parameter int         ADDR_W  = 5,
    parameter logic [4:0] OFS_DB  = 5'h00,
    parameter logic [4:0] OFS_EN  = 5'h08,
    parameter logic [4:0] OFS_ERR = 5'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_wr,
    input  logic              snd_rd,
    input  logic [ADDR_W-1:0] snd_addr,
    input  logic [63:0]       snd_wdata,
    output logic [63:0]       snd_rdata,
    input  logic              rcv_wr,
    input  logic              rcv_rd,
    input  logic [ADDR_W-1:0] rcv_addr,
    input  logic [63:0]       rcv_wdata,
    output logic [63:0]       rcv_rdata,
    output logic              req_irq,
    output logic              done_irq
);
    logic            snd_post, snd_drop, rcv_db_wr, rcv_en_wr, err_clr;
    dbell_t          db_q;
    logic [EN_W-1:0] en_q;
    logic            err_q;
    logic [DW-1:0]   db_word;
    logic            busy_w, done_w;
    logic [MSG_W-1:0] msg_w;
    logic            unused_wbits;

    assign busy_w  = db_q.busy;
    assign done_w  = db_q.done;
    assign msg_w   = db_q.msg;
    assign db_word = pack_dbell(db_q);
    assign err_clr = snd_rd && (snd_addr == ADDR_W'(OFS_ERR));
    assign unused_wbits = ^{snd_wdata[DONE_BIT-1:MSG_W], rcv_wdata[DONE_BIT-1:EN_W]};

    dbl_write_arb #(.ADDR_W(ADDR_W), .OFS_DB(OFS_DB), .OFS_EN(OFS_EN)) u_arb (
        .snd_wr(snd_wr), .snd_addr(snd_addr), .rcv_wr(rcv_wr), .rcv_addr(rcv_addr),
        .busy(busy_w), .snd_post(snd_post), .snd_drop(snd_drop),
        .rcv_db_wr(rcv_db_wr), .rcv_en_wr(rcv_en_wr)
    );

    dbl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .snd_post(snd_post), .snd_drop(snd_drop),
        .rcv_db_wr(rcv_db_wr), .rcv_en_wr(rcv_en_wr), .err_clr(err_clr),
        .snd_wdata(snd_wdata), .rcv_wdata(rcv_wdata),
        .db_q(db_q), .en_q(en_q), .err_q(err_q)
    );

    dbl_irq u_irq (
        .clk(clk), .rst_n(rst_n), .busy(busy_w), .done(done_w), .en(en_q),
        .req_irq(req_irq), .done_irq(done_irq)
    );

    dbl_rd_port #(.ADDR_W(ADDR_W), .OFS_DB(OFS_DB), .OFS_EN(OFS_EN), .OFS_ERR(OFS_ERR)) u_rd_snd (
        .clk(clk), .rst_n(rst_n), .rd(snd_rd), .addr(snd_addr),
        .db_word(db_word), .en(en_q), .err(err_q), .rdata(snd_rdata)
    );

    dbl_rd_port #(.ADDR_W(ADDR_W), .OFS_DB(OFS_DB), .OFS_EN(OFS_EN), .OFS_ERR(OFS_ERR)) u_rd_rcv (
        .clk(clk), .rst_n(rst_n), .rd(rcv_rd), .addr(rcv_addr),
        .db_word(db_word), .en(en_q), .err(err_q), .rdata(rcv_rdata)
    );
endmodule

// File: rtl/ipc_doorbell_chk.sv
// Property checker for the doorbell, attached by bind.
// Assumes it sees the stored flags and message through the bind connections.
module ipc_doorbell_chk
    import ipc_doorbell_pkg::*;
#(
    parameter int         ADDR_W = 5,
    parameter logic [4:0] OFS_DB = 5'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snd_wr,
    input logic [ADDR_W-1:0] snd_addr,
    input logic              rcv_wr,
    input logic [ADDR_W-1:0] rcv_addr,
    input logic [63:0]       rcv_wdata,
    input logic [63:0]       snd_rdata,
    input logic [63:0]       rcv_rdata,
    input logic              req_irq,
    input logic              done_irq,
    input logic              busy,
    input logic              done,
    input logic [MSG_W-1:0]  msg,
    input logic [EN_W-1:0]   en,
    input logic              err
);
    logic past_ok;
    logic snd_db, rcv_db;
    logic unused_chk;

    assign snd_db = snd_wr && (snd_addr == ADDR_W'(OFS_DB));
    assign rcv_db = rcv_wr && (rcv_addr == ADDR_W'(OFS_DB));
    assign unused_chk = ^{rcv_wdata[DONE_BIT:0]};

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (snd_rdata[61:30] == '0 && rcv_rdata[61:30] == '0));

    p_req_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (req_irq == $past(busy && en[EN_REQ_BIT])));

    p_done_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (done_irq == $past(done && en[EN_DONE_BIT])));

    p_drop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && snd_db && busy) |=> $stable(msg));

    p_rcv_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && snd_db && rcv_db) |=> (busy == $past(rcv_wdata[BUSY_BIT])));

    p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && snd_db && (busy || rcv_db)) |=> err);
endmodule

bind ipc_doorbell ipc_doorbell_chk #(.ADDR_W(ADDR_W), .OFS_DB(OFS_DB)) u_chk (
    .clk(clk), .rst_n(rst_n), .snd_wr(snd_wr), .snd_addr(snd_addr),
    .rcv_wr(rcv_wr), .rcv_addr(rcv_addr), .rcv_wdata(rcv_wdata),
    .snd_rdata(snd_rdata), .rcv_rdata(rcv_rdata),
    .req_irq(req_irq), .done_irq(done_irq),
    .busy(busy_w), .done(done_w), .msg(msg_w), .en(en_q), .err(err_q)
);

// File: tb/test_ipc_doorbell.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module test_ipc_doorbell;
    localparam int         ADDR_W  = 5;
    localparam logic [4:0] A_DB    = 5'h00;
    localparam logic [4:0] A_EN    = 5'h08;
    localparam logic [4:0] A_ERR   = 5'h10;
    localparam logic [4:0] A_NONE  = 5'h18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snd_wr = 1'b0, snd_rd = 1'b0, rcv_wr = 1'b0, rcv_rd = 1'b0;
    logic [ADDR_W-1:0] snd_addr = '0, rcv_addr = '0;
    logic [63:0] snd_wdata = '0, rcv_wdata = '0;
    logic [63:0] snd_rdata, rcv_rdata;
    logic req_irq, done_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] q_snd[$];
    logic [63:0] q_rcv[$];
    string t_snd[$];
    string t_rcv[$];
    logic pend_s = 1'b0, pend_r = 1'b0;

    always #2 clk = ~clk;

    ipc_doorbell #(.ADDR_W(ADDR_W)) i_ipc_doorbell (
        .clk(clk), .rst_n(rst_n),
        .snd_wr(snd_wr), .snd_rd(snd_rd), .snd_addr(snd_addr),
        .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
        .rcv_wr(rcv_wr), .rcv_rd(rcv_rd), .rcv_addr(rcv_addr),
        .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
        .req_irq(req_irq), .done_irq(done_irq)
    );

    // Note which ports were read at this edge.
    always @(posedge clk) begin
        pend_s <= snd_rd;
        pend_r <= rcv_rd;
    end

    // Monitor: compare returned read data with the queued expectation.
    always @(negedge clk) begin
        if (pend_s) begin
            n_chk++;
            if (q_snd.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected sender read data %h expected none", snd_rdata);
            end else begin
                logic [63:0] e;
                string t;
                e = q_snd.pop_front();
                t = t_snd.pop_front();
                if (snd_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: snd_rdata=%h expected %h", t, snd_rdata, e);
                end
            end
        end
        if (pend_r) begin
            n_chk++;
            if (q_rcv.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected receiver read data %h expected none", rcv_rdata);
            end else begin
                logic [63:0] e;
                string t;
                e = q_rcv.pop_front();
                t = t_rcv.pop_front();
                if (rcv_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: rcv_rdata=%h expected %h", t, rcv_rdata, e);
                end
            end
        end
    end

    task automatic cyc(input logic sw, input logic [4:0] sa, input logic [63:0] sd,
                       input logic rw, input logic [4:0] ra, input logic [63:0] rd);
        snd_wr = sw; snd_addr = sa; snd_wdata = sd;
        rcv_wr = rw; rcv_addr = ra; rcv_wdata = rd;
        @(negedge clk);
        snd_wr = 1'b0; rcv_wr = 1'b0;
    endtask

    task automatic rd_snd(input logic [4:0] a, input logic [63:0] e, input string t);
        snd_rd = 1'b1; snd_addr = a;
        q_snd.push_back(e); t_snd.push_back(t);
        @(negedge clk);
        snd_rd = 1'b0;
    endtask

    task automatic rd_rcv(input logic [4:0] a, input logic [63:0] e, input string t);
        rcv_rd = 1'b1; rcv_addr = a;
        q_rcv.push_back(e); t_rcv.push_back(t);
        @(negedge clk);
        rcv_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic er, input logic ed, input string t);
        n_chk++;
        if (req_irq !== er || done_irq !== ed) begin
            n_fail++;
            $display("FAIL %s: req_irq=%b done_irq=%b expected %b %b", t, req_irq, done_irq, er, ed);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run still active, expected completion");
        finish_test();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_irq(1'b0, 1'b0, "R1 irq in reset");
        rst_n = 1'b1;
        rd_snd(A_DB, 64'h0, "R1 doorbell reset");
        rd_rcv(A_EN, 64'h0, "R1 enable reset");
        rd_snd(A_ERR, 64'h0, "R1 error reset");
        chk_irq(1'b0, 1'b0, "R1 irq after reset");

        // R7: enables written by receiver, only bits 1:0 kept.
        cyc(1'b0, A_DB, '0, 1'b1, A_EN, '1);
        rd_rcv(A_EN, 64'h3, "R7 enable write");
        cyc(1'b1, A_EN, 64'h0, 1'b0, A_DB, '0);
        rd_snd(A_EN, 64'h3, "R7 sender enable write ignored");

        // R2/R3/R4: post with reserved bits set.
        cyc(1'b1, A_DB, 64'hBFFF_FFFF_0123_4567, 1'b0, A_DB, '0);
        chk_irq(1'b0, 1'b0, "R4 one-cycle lag");
        @(negedge clk);
        chk_irq(1'b1, 1'b0, "R4 request raised");
        rd_snd(A_DB, 64'h8000_0000_0123_4567, "R2 R3 post readback");
        rd_rcv(A_DB, 64'h8000_0000_0123_4567, "R11 receiver view");

        // R8/R10: post while busy.
        cyc(1'b1, A_DB, 64'h8000_0000_0000_0AAA, 1'b0, A_DB, '0);
        rd_rcv(A_DB, 64'h8000_0000_0123_4567, "R8 busy post dropped");
        rd_snd(A_ERR, 64'h1, "R10 error set");
        rd_snd(A_ERR, 64'h0, "R10 error cleared by read");

        // R5/R6: acknowledge with done.
        cyc(1'b0, A_DB, '0, 1'b1, A_DB, 64'h4000_0000_0000_03FF);
        @(negedge clk);
        chk_irq(1'b0, 1'b1, "R4 R6 ack");
        rd_snd(A_DB, 64'h4000_0000_0123_4567, "R5 message kept");

        // R6: enable gating and clearing done.
        cyc(1'b0, A_DB, '0, 1'b1, A_EN, 64'h2);
        @(negedge clk);
        chk_irq(1'b0, 1'b0, "R6 done enable off");
        cyc(1'b0, A_DB, '0, 1'b1, A_EN, 64'h3);
        @(negedge clk);
        chk_irq(1'b0, 1'b1, "R6 done enable on");
        cyc(1'b0, A_DB, '0, 1'b1, A_DB, 64'h0);
        @(negedge clk);
        chk_irq(1'b0, 1'b0, "R6 done cleared");

        // R9: same-cycle writes.
        cyc(1'b1, A_DB, 64'h8000_0000_0000_0055, 1'b1, A_DB, 64'h4000_0000_0000_0000);
        @(negedge clk);
        chk_irq(1'b0, 1'b1, "R9 receiver wins irq");
        rd_snd(A_DB, 64'h4000_0000_0123_4567, "R9 receiver wins");
        rd_rcv(A_ERR, 64'h1, "R11 receiver read keeps error");
        rd_snd(A_ERR, 64'h1, "R10 error after collision");
        rd_snd(A_ERR, 64'h0, "R10 error cleared");

        // R4: new post, then request enable removed.
        cyc(1'b1, A_DB, 64'h8000_0000_2000_0001, 1'b0, A_DB, '0);
        @(negedge clk);
        chk_irq(1'b1, 1'b0, "R4 second post");
        cyc(1'b0, A_DB, '0, 1'b1, A_EN, 64'h1);
        @(negedge clk);
        chk_irq(1'b0, 1'b0, "R4 request enable off");
        rd_rcv(A_DB, 64'h8000_0000_2000_0001, "R2 second post readback");

        // R11: unmapped offset.
        rd_snd(A_NONE, 64'h0, "R11 unmapped");
        repeat (2) @(negedge clk);
        finish_test();
    end
endmodule